// File: doc/BRIEF.md
# Tamper Event Timestamp Capture

This block freezes a copy of the running calendar time at the moment a tamper line is pulled. It watches a single tamper input that has already been synchronized to the system clock. An active transition on that line counts as an event. On an event the block copies the six BCD time fields presented on its time inputs into a bank of stamp registers. Those fields are seconds, minutes, hours, day of month, month and year. The event also raises two separate tamper flags, and either flag can drive an interrupt output when the interrupt is enabled.

Two control inputs shape the behaviour. The hold-first input keeps the earliest snapshot: once either flag is up, later events are discarded. With hold-first low, every event overwrites the bank. The capture-off input disables the function entirely. Each of the two flags has its own clear pulse, so software that owns them from different registers can release them independently. In hold-first mode, capture resumes only when both flags are down.

Top module: `tamper_stamp`

## Requirements
- R1: On a falling edge of `tamper_i` (previous cycle 1, this cycle 0) that is accepted, the stamp outputs show, from the next cycle on, the values that the time inputs carried in the edge cycle.
- R2: An accepted event sets both `flag_a_o` and `flag_b_o` in the following cycle.
- R3: With `keep_first_i` = 1, an event is ignored while either flag is 1. Stamps and flags are then unchanged.
- R4: With `keep_first_i` = 0, every event is accepted even when the flags are already set. It overwrites the stamps and keeps both flags at 1.
- R5: With `cap_off_i` = 1, events change neither the stamps nor the flags.
- R6: Stamp fields keep only their defined low bits, with the remaining bits reading 0: seconds 7 bits, minutes 7 bits, hours 6 bits, day of month 6 bits, month 5 bits and year 8 bits.
- R7: A one-cycle pulse on `clr_flag_a_i` or `clr_flag_b_i` clears only that flag in the next cycle. If an accepted event happens in the same cycle, the event wins and the flag stays 1.
- R8: `irq_o` is 1 exactly when `irq_en_i` is 1 and at least one flag is 1, in the same cycle.
- R9: After reset, both flags, all stamps and `irq_o` are 0.
- R10: A rising edge on `tamper_i`, or the line being held low, does not capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tamper_i | input | 1 | Synchronized tamper line, idle high |
| cap_off_i | input | 1 | 1 disables capture |
| keep_first_i | input | 1 | 1 keeps the first event until both flags are cleared |
| irq_en_i | input | 1 | Tamper interrupt enable |
| clr_flag_a_i | input | 1 | Clear pulse for flag A |
| clr_flag_b_i | input | 1 | Clear pulse for flag B |
| sec_i | input | 8 | Current seconds, BCD |
| min_i | input | 8 | Current minutes, BCD |
| hour_i | input | 8 | Current hours, BCD |
| mday_i | input | 8 | Current day of month, BCD |
| month_i | input | 8 | Current month, BCD |
| year_i | input | 8 | Current year, BCD |
| flag_a_o | output | 1 | Tamper flag A |
| flag_b_o | output | 1 | Tamper flag B |
| irq_o | output | 1 | Tamper interrupt |
| stamp_sec_o | output | 8 | Captured seconds |
| stamp_min_o | output | 8 | Captured minutes |
| stamp_hour_o | output | 8 | Captured hours |
| stamp_mday_o | output | 8 | Captured day of month |
| stamp_month_o | output | 8 | Captured month |
| stamp_year_o | output | 8 | Captured year |

## Verification
The bench sweeps every combination of hold-first, capture-off, interrupt enable and the four prior flag states before each event. It targets the case where only one flag has been cleared, where a design that tests only one flag would wrongly re-arm capture. The time inputs carry ones in their undefined high bits. A design that stored whole bytes would show those bits in the stamps. Further cases cover a clear pulse landing in the same cycle as an event, which a design giving the clear priority would lose, and a line held low or released. A level-triggered design would re-capture in those cases and so overwrite the stamps.

// File: rtl/tstamp_pkg.sv
package tstamp_pkg;
   localparam int N_FIELDS = 6;
   localparam int BYTE_W   = 8;
   localparam int N_FLAGS  = 2;
   // field order: seconds, minutes, hours, day of month, month, year
   localparam int FIELD_W [N_FIELDS] = '{7, 7, 6, 6, 5, 8};

   typedef logic [N_FIELDS-1:0][BYTE_W-1:0] bcd_bank_t;

   typedef enum logic [1:0] {
      DEC_IDLE       = 2'd0,
      DEC_TAKE       = 2'd1,
      DEC_BLOCK_OFF  = 2'd2,
      DEC_BLOCK_HELD = 2'd3
   } decision_t;
endpackage

// File: rtl/tstamp_edge.sv
module tstamp_edge #(
   parameter bit TRIG_FALL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic event_o
);
   logic pin_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin_q <= TRIG_FALL;
      else        pin_q <= pin_i;
   end

   generate
      if (TRIG_FALL) begin : g_fall
         assign event_o = pin_q & ~pin_i;
      end else begin : g_rise
         assign event_o = ~pin_q & pin_i;
      end
   endgenerate
endmodule

// File: rtl/tstamp_gate.sv
module tstamp_gate
   import tstamp_pkg::*;
#(
   parameter int NF = N_FLAGS
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          event_i,
   input  logic          off_i,
   input  logic          keep_first_i,
   input  logic [NF-1:0] clr_i,
   output logic          take_o,
   output logic [NF-1:0] flags_o
);
   decision_t dec;

   generate
      if (NF < 1) begin : g_bad_nf
         $error("tstamp_gate needs at least one flag");
      end
   endgenerate

   always_comb begin
      if (!event_i)                       dec = DEC_IDLE;
      else if (off_i)                     dec = DEC_BLOCK_OFF;
      else if (keep_first_i && |flags_o)  dec = DEC_BLOCK_HELD;
      else                                dec = DEC_TAKE;
   end

   assign take_o = (dec == DEC_TAKE);

   generate
      for (genvar f = 0; f < NF; f++) begin : g_flag
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         flags_o[f] <= 1'b0;
            else if (take_o)    flags_o[f] <= 1'b1;
            else if (clr_i[f])  flags_o[f] <= 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/tstamp_store.sv
module tstamp_store
   import tstamp_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      take_i,
   input  bcd_bank_t now_i,
   output bcd_bank_t stamp_o
);
   generate
      for (genvar g = 0; g < N_FIELDS; g++) begin : g_field
         localparam int W = FIELD_W[g];
         if (W < 1 || W > BYTE_W) begin : g_bad_w
            $error("tstamp_store field width out of range");
         end
         localparam logic [BYTE_W-1:0] MASK = BYTE_W'((64'd1 << W) - 64'd1);
         logic [BYTE_W-1:0] r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      r <= '0;
            else if (take_i) r <= now_i[g] & MASK;
         end
         assign stamp_o[g] = r;
      end
   endgenerate
endmodule

// File: rtl/tamper_stamp.sv
module tamper_stamp
   import tstamp_pkg::*;
#(
   parameter bit TRIG_FALL = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tamper_i,
   input  logic       cap_off_i,
   input  logic       keep_first_i,
   input  logic       irq_en_i,
   input  logic       clr_flag_a_i,
   input  logic       clr_flag_b_i,
   input  logic [7:0] sec_i,
   input  logic [7:0] min_i,
   input  logic [7:0] hour_i,
   input  logic [7:0] mday_i,
   input  logic [7:0] month_i,
   input  logic [7:0] year_i,
   output logic       flag_a_o,
   output logic       flag_b_o,
   output logic       irq_o,
   output logic [7:0] stamp_sec_o,
   output logic [7:0] stamp_min_o,
   output logic [7:0] stamp_hour_o,
   output logic [7:0] stamp_mday_o,
   output logic [7:0] stamp_month_o,
   output logic [7:0] stamp_year_o
);
   logic               ev;
   logic               take;
   logic [N_FLAGS-1:0] flags;
   bcd_bank_t          now_bank;
   bcd_bank_t          stamp_bank;

   assign now_bank = {year_i, month_i, mday_i, hour_i, min_i, sec_i};

   tstamp_edge #(.TRIG_FALL(TRIG_FALL)) u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_i   (tamper_i),
      .event_o (ev)
   );

   tstamp_gate #(.NF(N_FLAGS)) u_gate (
      .clk          (clk),
      .rst_n        (rst_n),
      .event_i      (ev),
      .off_i        (cap_off_i),
      .keep_first_i (keep_first_i),
      .clr_i        ({clr_flag_b_i, clr_flag_a_i}),
      .take_o       (take),
      .flags_o      (flags)
   );

   tstamp_store u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .take_i  (take),
      .now_i   (now_bank),
      .stamp_o (stamp_bank)
   );

   assign flag_a_o      = flags[0];
   assign flag_b_o      = flags[1];
   assign irq_o         = irq_en_i & (|flags);
   assign stamp_sec_o   = stamp_bank[0];
   assign stamp_min_o   = stamp_bank[1];
   assign stamp_hour_o  = stamp_bank[2];
   assign stamp_mday_o  = stamp_bank[3];
   assign stamp_month_o = stamp_bank[4];
   assign stamp_year_o  = stamp_bank[5];
endmodule

// File: rtl/tamper_stamp_chk.sv
module tamper_stamp_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       tamper_i,
   input logic       cap_off_i,
   input logic       keep_first_i,
   input logic       irq_en_i,
   input logic       clr_flag_a_i,
   input logic [7:0] year_i,
   input logic       flag_a_o,
   input logic       flag_b_o,
   input logic       irq_o,
   input logic [7:0] stamp_sec_o,
   input logic [7:0] stamp_min_o,
   input logic [7:0] stamp_hour_o,
   input logic [7:0] stamp_mday_o,
   input logic [7:0] stamp_month_o,
   input logic [7:0] stamp_year_o
);
   logic [47:0] bank;
   assign bank = {stamp_year_o, stamp_month_o, stamp_mday_o,
                  stamp_hour_o, stamp_min_o, stamp_sec_o};

   // R1: accepted event copies year input into the stamp
   p_capture_year_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(tamper_i) && !cap_off_i && !keep_first_i) |=> stamp_year_o == $past(year_i));

   // R2: accepted event raises both flags
   p_flags_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(tamper_i) && !cap_off_i && !keep_first_i) |=> (flag_a_o && flag_b_o));

   // R3: held snapshot does not move
   p_hold_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (keep_first_i && (flag_a_o || flag_b_o)) |=> $stable(bank));

   // R5: disabled capture leaves stamps alone and raises no flag
   p_off_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cap_off_i |=> $stable(bank));
   p_off_no_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_off_i && !flag_a_o) |=> !flag_a_o);

   // R6: undefined month and hour bits stay zero
   p_field_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (stamp_month_o[7:5] == 3'b000) && (stamp_hour_o[7:6] == 2'b00) && !stamp_sec_o[7]);

   // R7: clear without event drops flag A
   p_clear_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_flag_a_i && !$fell(tamper_i)) |=> !flag_a_o);

   // R8: enabled interrupt follows a raised flag
   p_irq_on_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_en_i && (flag_a_o || flag_b_o)) |-> irq_o);

   // R10: no capture without a falling edge
   p_no_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !$fell(tamper_i) |=> $stable(bank));
endmodule

bind tamper_stamp tamper_stamp_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .tamper_i      (tamper_i),
   .cap_off_i     (cap_off_i),
   .keep_first_i  (keep_first_i),
   .irq_en_i      (irq_en_i),
   .clr_flag_a_i  (clr_flag_a_i),
   .year_i        (year_i),
   .flag_a_o      (flag_a_o),
   .flag_b_o      (flag_b_o),
   .irq_o         (irq_o),
   .stamp_sec_o   (stamp_sec_o),
   .stamp_min_o   (stamp_min_o),
   .stamp_hour_o  (stamp_hour_o),
   .stamp_mday_o  (stamp_mday_o),
   .stamp_month_o (stamp_month_o),
   .stamp_year_o  (stamp_year_o)
);

// File: tb/tamper_stamp_tb.sv
module tamper_stamp_tb;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tam = 1'b1, off = 1'b0, keep = 1'b0, ien = 1'b0, ca = 1'b0, cb = 1'b0;
   logic [7:0] now [6];
   logic fa, fb, irq;
   logic [7:0] st [6];

   int checks = 0;
   int errors = 0;

   // reference state
   logic       m_prev, m_fa, m_fb;
   logic [7:0] m_st [6];
   int         fw [6] = '{7, 7, 6, 6, 5, 8};

   always #(CLK_PERIOD/2) clk = ~clk;

   tamper_stamp u_dut (
      .clk(clk), .rst_n(rst_n), .tamper_i(tam), .cap_off_i(off),
      .keep_first_i(keep), .irq_en_i(ien), .clr_flag_a_i(ca), .clr_flag_b_i(cb),
      .sec_i(now[0]), .min_i(now[1]), .hour_i(now[2]), .mday_i(now[3]),
      .month_i(now[4]), .year_i(now[5]),
      .flag_a_o(fa), .flag_b_o(fb), .irq_o(irq),
      .stamp_sec_o(st[0]), .stamp_min_o(st[1]), .stamp_hour_o(st[2]),
      .stamp_mday_o(st[3]), .stamp_month_o(st[4]), .stamp_year_o(st[5])
   );

   task automatic chk(string tag, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic compare(string tag);
      chk(tag, "flag_a", int'(fa), int'(m_fa));
      chk(tag, "flag_b", int'(fb), int'(m_fb));
      chk("R8", "irq", int'(irq), int'(ien & (m_fa | m_fb)));
      for (int k = 0; k < 6; k++) chk(tag, $sformatf("stamp[%0d]", k), int'(st[k]), int'(m_st[k]));
   endtask

   // one clock: model from current inputs, then compare away from the edge
   task automatic cycle(string tag);
      logic ev, take;
      ev   = m_prev & ~tam;
      take = ev & ~off & ~(keep & (m_fa | m_fb));
      @(posedge clk);
      if (take) begin
         m_fa = 1'b1; m_fb = 1'b1;
         for (int k = 0; k < 6; k++) m_st[k] = now[k] & 8'(((1 << fw[k]) - 1));
      end else begin
         if (ca) m_fa = 1'b0;
         if (cb) m_fb = 1'b0;
      end
      m_prev = tam;
      @(negedge clk);
      compare(tag);
   endtask

   task automatic set_now(int seed);
      for (int k = 0; k < 6; k++) now[k] = 8'(seed * 37 + k * 29 + 8'hE1);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      set_now(0);
      m_prev = 1'b1; m_fa = 1'b0; m_fb = 1'b0;
      for (int k = 0; k < 6; k++) m_st[k] = 8'h00;
      repeat (3) @(negedge clk);
      ien = 1'b1;
      compare("R9");
      rst_n = 1'b1;
      cycle("R9");

      // sweep: mode x off x prior flag state x interrupt enable
      for (int mode = 0; mode < 2; mode++)
         for (int dis = 0; dis < 2; dis++)
            for (int pre = 0; pre < 4; pre++)
               for (int ie = 0; ie < 2; ie++) begin
                  string te;
                  off = 1'b0; keep = 1'b0; ien = ie[0];
                  ca = 1'b1; cb = 1'b1; cycle("R7");
                  ca = 1'b0; cb = 1'b0;
                  if (pre != 0) begin
                     set_now(pre + ie * 5);
                     tam = 1'b0; cycle("R2");
                     tam = 1'b1; cycle("R2");
                     ca = ~pre[0]; cb = ~pre[1]; cycle("R7");
                     ca = 1'b0; cb = 1'b0;
                  end
                  set_now(mode * 16 + dis * 8 + pre * 2 + ie + 40);
                  keep = mode[0]; off = dis[0];
                  if (dis != 0)                   te = "R5";
                  else if (mode != 0 && pre != 0) te = "R3";
                  else if (mode != 0)             te = "R1";
                  else                            te = "R4";
                  tam = 1'b0; cycle(te);
                  tam = 1'b1; cycle("R6");
                  cycle("R8");
               end

      // line held low and released: no capture
      off = 1'b0; keep = 1'b0; ien = 1'b1;
      set_now(90);
      tam = 1'b0; cycle("R1");
      set_now(91); cycle("R10");
      set_now(92); cycle("R10");
      tam = 1'b1; set_now(93); cycle("R10");
      cycle("R10");

      // clear pulse in the same cycle as an accepted event: event wins
      ca = 1'b1; cb = 1'b1; tam = 1'b0; set_now(94); cycle("R7");
      ca = 1'b0; cb = 1'b0; tam = 1'b1; cycle("R7");
      chk("R7", "flag_a kept by simultaneous event", int'(fa), 1);

      // clear flag B only, interrupt disabled
      ien = 1'b0; cb = 1'b1; cycle("R7");
      cb = 1'b0; cycle("R8");
      chk("R7", "flag_b alone cleared", int'(fb), 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule